// File: doc/BRIEF.md
# PHY-Side Link Interface Control Sequencer

This block is the physical-layer end of the control handshake between a serial-bus PHY and its link controller. A 2-bit control bus and a byte-wide data bus join the two sides. The meaning of a control code depends on which side owns the bus at that moment. While the PHY owns it, the block drives idle, status, receive or grant. Once grant has been sent, the PHY stops driving both buses and decodes the codes the link drives back: release, hold or transmit.

Requests come from the rest of the PHY through a simple internal port. A status-ready pulse and a packet-received pulse each carry a byte count. An arbitration-won pulse asks for the bus to be granted. Each pulse is latched as pending until the sequencer can serve it, so none is lost while the interface is busy. Payload bytes are pulled from a byte source one per clock while the matching code is on the bus. The block also reports the operation in progress.

Top module: `phy_lnk_seq`

## Requirements
- R1: After reset the control bus is driven (`ctl_oe_o`=1) with code 00, `op_o` reads 0 (idle), and `pay_rd_o`, `tx_valid_o` and `err_o` are low.
- R2: A `stat_req_i` pulse with count L (1..2^LEN_W-1) puts code 01 on the bus for L consecutive cycles. The first of these cycles follows the second rising edge after the pulse. In each of them `pay_rd_o`=1, `data_o` equals `pay_i`, and `op_o`=1.
- R3: An `rx_req_i` pulse with count L behaves like R2 but drives code 10 with `op_o`=2.
- R4: After the last byte of a status or receive burst, the control bus reads 00 for at least one cycle before any other operation starts.
- R5: If a packet-received request and a status request are both pending, the receive burst is sent first. The status burst starts after the one idle cycle that follows it.
- R6: An `arb_won_i` pulse causes code 11 (grant, `op_o`=3) to be driven for exactly one cycle, with the same two-edge latency as R2. Pending work is served in the order receive, then grant, then status.
- R7: From the cycle after grant until the link releases, `ctl_oe_o` and `data_oe_o` are 0. Link code 01 is reported as hold (`op_o`=4). Link code 10 is reported as transmit (`op_o`=5), with `tx_valid_o`=1 and `tx_data_o` equal to `data_i`.
- R8: Link code 11 is handled as hold (`op_o`=4) and raises `err_o` for each cycle it is sampled.
- R9: Link code 00 returns ownership. In that cycle `op_o`=0 and the buses stay released. In the next cycle the PHY drives code 00.
- R10: A request that arrives while the interface is busy stays pending and is served once the interface is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_req_i | input | 1 | Status transfer ready (pulse) |
| stat_len_i | input | LEN_W | Status byte count |
| rx_req_i | input | 1 | Packet received (pulse) |
| rx_len_i | input | LEN_W | Receive byte count |
| arb_won_i | input | 1 | Serial-bus arbitration won (pulse) |
| pay_i | input | DATA_W | Byte to present in the current burst cycle |
| pay_rd_o | output | 1 | Byte on `pay_i` consumed this cycle |
| ctl_i | input | 2 | Control code from the link |
| ctl_o | output | 2 | Control code to the link |
| ctl_oe_o | output | 1 | Control bus output enable |
| data_i | input | DATA_W | Data from the link |
| data_o | output | DATA_W | Data to the link |
| data_oe_o | output | 1 | Data bus output enable |
| tx_valid_o | output | 1 | Link is transmitting a byte this cycle |
| tx_data_o | output | DATA_W | Transmitted byte |
| err_o | output | 1 | Reserved link code seen |
| op_o | output | 3 | Current operation: 0 idle, 1 status, 2 receive, 3 grant, 4 hold, 5 transmit |

## Verification
Request pulses are registered as pending on the first edge. The sequencer acts on them at the second edge, so a burst or grant driven by a pulse issued in cycle c is visible from cycle c+2. Link codes are decoded in the same cycle they are applied, and a release shows as a PHY-driven idle one cycle later. The driver stamps every expected item with the cycle it is due in. The monitor compares each item at the falling edge of exactly that cycle, after inputs have been applied just past the rising edge. Any item that was never matched counts as a mismatch.

// File: rtl/phy_lnk_pkg.sv
`timescale 1ns/1ps
package phy_lnk_pkg;
  typedef enum logic [1:0] {
    PC_IDLE  = 2'b00,
    PC_STAT  = 2'b01,
    PC_RECV  = 2'b10,
    PC_GRANT = 2'b11
  } phy_code_e;

  typedef enum logic [1:0] {
    LC_RELEASE = 2'b00,
    LC_HOLD    = 2'b01,
    LC_XMIT    = 2'b10,
    LC_RSVD    = 2'b11
  } link_code_e;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_STAT  = 3'd1,
    OP_RECV  = 3'd2,
    OP_GRANT = 3'd3,
    OP_HOLD  = 3'd4,
    OP_XMIT  = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_STAT  = 3'd1,
    S_RECV  = 3'd2,
    S_GRANT = 3'd3,
    S_LINK  = 3'd4
  } state_e;
endpackage

// File: rtl/phy_lnk_pend.sv
`timescale 1ns/1ps
module phy_lnk_pend #(
  parameter int LEN_W   = 4,
  parameter bit HAS_LEN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             clr_i,
  output logic             pend_o,
  output logic [LEN_W-1:0] len_o
);
  logic pend_q;

  // a new request in the cycle its predecessor is taken stays pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end
  assign pend_o = pend_q;

  generate
    if (HAS_LEN) begin : g_len
      logic [LEN_W-1:0] len_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    len_q <= '0;
        else if (set_i) len_q <= len_i;
      end
      assign len_o = len_q;
    end else begin : g_nolen
      logic unused_len;
      assign unused_len = ^len_i;
      assign len_o      = '0;
    end
  endgenerate

  // R10
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o);
endmodule

// File: rtl/phy_lnk_ldec.sv
`timescale 1ns/1ps
module phy_lnk_ldec
  import phy_lnk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              own_i,
  input  logic [1:0]        ctl_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              release_o,
  output logic              hold_o,
  output logic              xmit_o,
  output logic              err_o,
  output logic [DATA_W-1:0] tx_data_o
);
  always_comb begin
    release_o = 1'b0;
    hold_o    = 1'b0;
    xmit_o    = 1'b0;
    err_o     = 1'b0;
    if (own_i) begin
      unique case (link_code_e'(ctl_i))
        LC_RELEASE: release_o = 1'b1;
        LC_HOLD:    hold_o    = 1'b1;
        LC_XMIT:    xmit_o    = 1'b1;
        LC_RSVD: begin
          hold_o = 1'b1;  // reserved treated as hold
          err_o  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign tx_data_o = xmit_o ? data_i : '0;
endmodule

// File: rtl/phy_lnk_fsm.sv
`timescale 1ns/1ps
module phy_lnk_fsm
  import phy_lnk_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_pend_i,
  input  logic [LEN_W-1:0] rx_len_i,
  input  logic             stat_pend_i,
  input  logic [LEN_W-1:0] stat_len_i,
  input  logic             arb_pend_i,
  input  logic             release_i,
  output state_e           state_o,
  output logic             clr_rx_o,
  output logic             clr_stat_o,
  output logic             clr_arb_o
);
  state_e           state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;

  function automatic logic [LEN_W-1:0] last_idx(input logic [LEN_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    clr_rx_o   = 1'b0;
    clr_stat_o = 1'b0;
    clr_arb_o  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (rx_pend_i) begin
          state_d  = S_RECV;
          cnt_d    = last_idx(rx_len_i);
          clr_rx_o = 1'b1;
        end else if (arb_pend_i) begin
          state_d   = S_GRANT;
          clr_arb_o = 1'b1;
        end else if (stat_pend_i) begin
          state_d    = S_STAT;
          cnt_d      = last_idx(stat_len_i);
          clr_stat_o = 1'b1;
        end
      end
      S_STAT, S_RECV: begin
        if (cnt_q == '0) state_d = S_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      S_GRANT: state_d = S_LINK;
      S_LINK:  if (release_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  // R5
  rx_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && rx_pend_i && stat_pend_i) |=> (state_q == S_RECV));

  // R4
  idle_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {S_STAT, S_RECV} && cnt_q == '0) |=> (state_q == S_IDLE));
endmodule

// File: rtl/phy_lnk_seq.sv
`timescale 1ns/1ps
module phy_lnk_seq
  import phy_lnk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stat_req_i,
  input  logic [LEN_W-1:0]  stat_len_i,
  input  logic              rx_req_i,
  input  logic [LEN_W-1:0]  rx_len_i,
  input  logic              arb_won_i,
  input  logic [DATA_W-1:0] pay_i,
  output logic              pay_rd_o,
  input  logic [1:0]        ctl_i,
  output logic [1:0]        ctl_o,
  output logic              ctl_oe_o,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              err_o,
  output logic [2:0]        op_o
);
  localparam int NCH = 3;  // 0 receive, 1 status, 2 arbitration

  logic [NCH-1:0]            ch_set, ch_clr, ch_pend;
  logic [NCH-1:0][LEN_W-1:0] ch_len_in, ch_len;
  state_e                    state;
  logic                      link_own, rel, hold, xmit, rsvd;

  assign ch_set    = {arb_won_i, stat_req_i, rx_req_i};
  assign ch_len_in = {{LEN_W{1'b0}}, stat_len_i, rx_len_i};

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      phy_lnk_pend #(.LEN_W(LEN_W), .HAS_LEN(g != NCH - 1)) i_pend (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (ch_set[g]),
        .len_i (ch_len_in[g]),
        .clr_i (ch_clr[g]),
        .pend_o(ch_pend[g]),
        .len_o (ch_len[g])
      );
    end
  endgenerate

  phy_lnk_fsm #(.LEN_W(LEN_W)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_pend_i  (ch_pend[0]),
    .rx_len_i   (ch_len[0]),
    .stat_pend_i(ch_pend[1]),
    .stat_len_i (ch_len[1]),
    .arb_pend_i (ch_pend[2]),
    .release_i  (rel),
    .state_o    (state),
    .clr_rx_o   (ch_clr[0]),
    .clr_stat_o (ch_clr[1]),
    .clr_arb_o  (ch_clr[2])
  );

  logic unused_arb_len;
  assign unused_arb_len = ^ch_len[2];

  assign link_own = (state == S_LINK);

  phy_lnk_ldec #(.DATA_W(DATA_W)) i_ldec (
    .own_i    (link_own),
    .ctl_i    (ctl_i),
    .data_i   (data_i),
    .release_o(rel),
    .hold_o   (hold),
    .xmit_o   (xmit),
    .err_o    (rsvd),
    .tx_data_o(tx_data_o)
  );

  always_comb begin
    unique case (state)
      S_STAT:  ctl_o = PC_STAT;
      S_RECV:  ctl_o = PC_RECV;
      S_GRANT: ctl_o = PC_GRANT;
      default: ctl_o = PC_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      S_STAT:  op_o = OP_STAT;
      S_RECV:  op_o = OP_RECV;
      S_GRANT: op_o = OP_GRANT;
      S_LINK:  op_o = xmit ? OP_XMIT : (hold ? OP_HOLD : OP_IDLE);
      default: op_o = OP_IDLE;
    endcase
  end

  assign ctl_oe_o   = !link_own;
  assign data_oe_o  = !link_own;
  assign pay_rd_o   = (state == S_STAT) || (state == S_RECV);
  assign data_o     = pay_rd_o ? pay_i : '0;
  assign tx_valid_o = xmit;
  assign err_o      = rsvd;

  // R6
  grant_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_oe_o && ctl_o == 2'b11) |=> !ctl_oe_o);

  // R7
  bus_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o || err_o) |-> (!ctl_oe_o && !data_oe_o));

  // R8
  rsvd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (op_o == 3'd4));

  // R9
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_oe_o && ctl_i == 2'b00) |=> (ctl_oe_o && ctl_o == 2'b00));

  // R4
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pay_rd_o) |-> (ctl_oe_o && ctl_o == 2'b00));

  // R2
  rd_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_rd_o |-> (ctl_oe_o && (ctl_o == 2'b01 || ctl_o == 2'b10)));
endmodule

// File: tb/test_phy_lnk_seq.sv
`timescale 1ns/1ps
module test_phy_lnk_seq;
  localparam int DW = 8;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stat_req = 1'b0, rx_req = 1'b0, arb_won = 1'b0;
  logic [LW-1:0] stat_len = '0, rx_len = '0;
  logic [DW-1:0] pay;
  logic          pay_rd;
  logic [1:0]    ctl_in = 2'b00, ctl_out;
  logic          ctl_oe, data_oe, tx_valid, err;
  logic [DW-1:0] data_in = '0, data_out, tx_data;
  logic [2:0]    op;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign pay = 8'(cyc) ^ 8'h5A;

  phy_lnk_seq #(.DATA_W(DW), .LEN_W(LW)) i_phy_lnk_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .stat_req_i(stat_req), .stat_len_i(stat_len),
    .rx_req_i(rx_req), .rx_len_i(rx_len), .arb_won_i(arb_won),
    .pay_i(pay), .pay_rd_o(pay_rd),
    .ctl_i(ctl_in), .ctl_o(ctl_out), .ctl_oe_o(ctl_oe),
    .data_i(data_in), .data_o(data_out), .data_oe_o(data_oe),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .err_o(err), .op_o(op)
  );

  typedef struct {
    int          cyc;
    logic [1:0]  ctl;
    logic        oe;
    logic [7:0]  dat;
    logic        rd;
    logic        tv;
    logic [7:0]  td;
    logic        er;
    logic [2:0]  op;
    string       req;
  } exp_t;

  exp_t exp_q[$];

  task automatic push(int c, logic [1:0] ctl, logic oe, logic [7:0] d, logic rd,
                      logic tv, logic [7:0] td, logic er, logic [2:0] o, string r);
    exp_t e;
    e.cyc = c; e.ctl = ctl; e.oe = oe; e.dat = d; e.rd = rd;
    e.tv = tv; e.td = td; e.er = er; e.op = o; e.req = r;
    exp_q.push_back(e);
  endtask

  task automatic exp_idle(int c, string r);
    push(c, 2'b00, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 3'd0, r);
  endtask

  task automatic exp_burst(int c0, int len, logic [1:0] code, logic [2:0] o, string r);
    for (int i = 0; i < len; i++)
      push(c0 + i, code, 1'b1, 8'(c0 + i) ^ 8'h5A, 1'b1, 1'b0, 8'h00, 1'b0, o, r);
  endtask

  task automatic exp_link(int c, logic tv, logic [7:0] td, logic er, logic [2:0] o, string r);
    push(c, 2'b00, 1'b0, 8'h00, 1'b0, tv, td, er, o, r);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
        exp_t e;
        logic ok;
        e = exp_q.pop_front();
        n_cmp++;
        if (e.cyc < cyc) begin
          n_bad++;
          $display("FAIL %s: item for cycle %0d missed (actual cycle %0d, expected %0d)",
                   e.req, e.cyc, cyc, e.cyc);
        end else begin
          ok = (ctl_oe === e.oe) && (data_oe === e.oe) && (pay_rd === e.rd) &&
               (tx_valid === e.tv) && (err === e.er) && (op === e.op);
          if (e.oe)  ok = ok && (ctl_out === e.ctl) && (data_out === e.dat);
          if (e.tv)  ok = ok && (tx_data === e.td);
          if (!ok) begin
            n_bad++;
            $display("FAIL %s @%0d: actual ctl=%b oe=%b doe=%b d=%h rd=%b tv=%b td=%h err=%b op=%0d expected ctl=%b oe=%b d=%h rd=%b tv=%b td=%h err=%b op=%0d",
                     e.req, cyc, ctl_out, ctl_oe, data_oe, data_out, pay_rd, tx_valid, tx_data, err, op,
                     e.ctl, e.oe, e.dat, e.rd, e.tv, e.td, e.er, e.op);
          end
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic run_stat(int len);
    int c;
    step();
    c = cyc;
    stat_len = LW'(len); stat_req = 1'b1;
    exp_burst(c + 2, len, 2'b01, 3'd1, "R2");
    exp_idle(c + 2 + len, "R4");
    step();
    stat_req = 1'b0;
    repeat (len + 3) step();
  endtask

  task automatic run_rx(int len);
    int c;
    step();
    c = cyc;
    rx_len = LW'(len); rx_req = 1'b1;
    exp_burst(c + 2, len, 2'b10, 3'd2, "R3");
    exp_idle(c + 2 + len, "R4");
    step();
    rx_req = 1'b0;
    repeat (len + 3) step();
  endtask

  initial begin
    int c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    c = cyc;
    exp_idle(c + 1, "R1");
    exp_idle(c + 2, "R1");
    repeat (3) step();

    run_stat(1);
    run_stat(5);
    run_rx(3);
    run_rx(15);

    // R5 simultaneous receive and status
    step(); c = cyc;
    rx_len = 4'd2; rx_req = 1'b1; stat_len = 4'd3; stat_req = 1'b1;
    exp_burst(c + 2, 2, 2'b10, 3'd2, "R5");
    exp_idle(c + 4, "R5");
    exp_burst(c + 5, 3, 2'b01, 3'd1, "R5");
    exp_idle(c + 8, "R4");
    step(); rx_req = 1'b0; stat_req = 1'b0;
    repeat (9) step();

    // R10 status arriving during receive
    step(); c = cyc;
    rx_len = 4'd4; rx_req = 1'b1;
    exp_burst(c + 2, 4, 2'b10, 3'd2, "R10");
    exp_idle(c + 6, "R10");
    exp_burst(c + 7, 1, 2'b01, 3'd1, "R10");
    exp_idle(c + 8, "R10");
    step(); rx_req = 1'b0;
    step(); step(); stat_len = 4'd1; stat_req = 1'b1;
    step(); stat_req = 1'b0;
    repeat (7) step();

    // R6-R9 grant, link ownership, release, deferred receive
    step(); c = cyc;
    arb_won = 1'b1; ctl_in = 2'b01; data_in = 8'h33;
    push(c + 2, 2'b11, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 3'd3, "R6");
    exp_link(c + 3, 1'b0, 8'h00, 1'b0, 3'd4, "R7");
    exp_link(c + 4, 1'b1, 8'hC4, 1'b0, 3'd5, "R7");
    exp_link(c + 5, 1'b0, 8'h00, 1'b1, 3'd4, "R8");
    exp_link(c + 6, 1'b0, 8'h00, 1'b0, 3'd4, "R8");
    exp_link(c + 7, 1'b0, 8'h00, 1'b0, 3'd0, "R9");
    exp_idle(c + 8, "R9");
    exp_burst(c + 9, 1, 2'b10, 3'd2, "R10");
    exp_idle(c + 10, "R4");
    step(); arb_won = 1'b0;                            // c+1
    step();                                            // c+2 grant
    step();                                            // c+3 hold
    step(); ctl_in = 2'b10; data_in = 8'hC4;           // c+4 transmit
    step(); ctl_in = 2'b11; data_in = 8'h00;           // c+5 reserved
    step(); ctl_in = 2'b01; rx_len = 4'd1; rx_req = 1'b1; // c+6
    step(); ctl_in = 2'b00; rx_req = 1'b0;             // c+7 release
    repeat (6) step();

    // R6 grant ahead of status; link releases right away
    step(); c = cyc;
    arb_won = 1'b1; stat_req = 1'b1; stat_len = 4'd2; ctl_in = 2'b00;
    push(c + 2, 2'b11, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 3'd3, "R6");
    exp_link(c + 3, 1'b0, 8'h00, 1'b0, 3'd0, "R9");
    exp_idle(c + 4, "R9");
    exp_burst(c + 5, 2, 2'b01, 3'd1, "R6");
    exp_idle(c + 7, "R4");
    step(); arb_won = 1'b0; stat_req = 1'b0;
    repeat (9) step();

    if (exp_q.size() != 0) begin
      n_bad += exp_q.size();
      $display("FAIL R1: %0d expected items unmatched (actual %0d, expected 0)", exp_q.size(), exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R1: watchdog expired (actual hung, expected finish)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule